// File: doc/BRIEF.md
# Two-Bank Interleavable Word Store

This block is a small read/write store of 32 words, each 3 bits wide, assembled from two banks of 16 words. Every data bit of a bank is held in its own 16-entry single-bit slice, so a bank is a stack of three slices that share a row index and a write strobe. A 5-bit word address reaches the store, and a build-time parameter decides which address bit steers between the two banks.

With the default mapping the most significant address bit picks the bank and the remaining four bits pick the row, so words 0 to 15 sit in one bank and words 16 to 31 in the other. With the interleaved mapping the least significant bit picks the bank and the upper four bits pick the row, so consecutive addresses alternate between banks. Seen from the ports both mappings hold the same 32 independent words.

Access is controlled by a chip select, a direction input (high for read, low for write) and a global enable. The global enable is ANDed into each bank's select, so neither bank is touched while it is low. Writes land on the clock edge. Read data is captured into a 3-bit output buffer register on the edge that ends the read cycle, and the buffer keeps its value in every cycle that is not a read.

Top module: `two_bank_mem`

## Requirements
- R1: Each of the 32 addresses holds its own 3-bit word: after a write of value v to address a, a later read of a returns v until a is written again.
- R2: With the default mapping, address bit 4 selects the bank (0 for words 0 to 15, 1 for words 16 to 31) and bits 3 down to 0 give the row.
- R3: With the interleaved mapping, address bit 0 selects the bank and bits 4 down to 1 give the row, so addresses a and a+1 lie in different banks.
- R4: A write changes only the addressed word; at most one bank is written in any cycle and every other word keeps its value.
- R5: While the global enable is low, no word is written and the output buffer keeps its value, whatever the select, direction, address and data inputs are.
- R6: While select is low, no word is written, for either value of the direction input.
- R7: With enable and select high and the direction input high (read), the word at the address is in the output buffer after the next rising clock edge.
- R8: In any cycle that is not an enabled, selected read, the output buffer keeps its value across the clock edge.
- R9: While reset is asserted and after its release, before the first read, the output buffer reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_en | input | 1 | Global enable, ANDed into both bank selects |
| sel | input | 1 | Chip select |
| rd_wr_n | input | 1 | Direction: 1 reads, 0 writes |
| addr | input | 5 | Word address 0 to 31 |
| wdata | input | 3 | Write data |
| rdata | output | 3 | Registered read buffer |

## Verification
The bench drives one instance of each mapping with the same stimulus and sweeps all 32 addresses, first filling every word, then rewriting only the even addresses so that a write that leaked into the wrong bank or the wrong row would show up as a corrupted neighbour on the read-back sweep. It then repeats full write sweeps with select low and with the global enable low; a design that ignored either gate would overwrite every word, and one that let a disabled read through would change the output buffer. Back-to-back reads of alternating addresses and a read straight after a write catch an output buffer that lags by a cycle or returns stale data, and the idle cycles between them catch a buffer that does not hold.

// File: rtl/bankmem_pkg.sv
package bankmem_pkg;

  // Which address bit steers between the two banks.
  typedef enum logic {
    MAP_HIGH_BIT = 1'b0,  // top bit picks the bank
    MAP_LOW_BIT  = 1'b1   // bottom bit picks the bank (interleaved)
  } bank_map_e;

endpackage

// File: rtl/bm_addr_split.sv
module bm_addr_split
  import bankmem_pkg::*;
#(
  parameter bank_map_e MAP   = MAP_HIGH_BIT,
  parameter int        ROW_W = 4,
  localparam int       AW    = ROW_W + 1
) (
  input  logic [AW-1:0]    addr,
  output logic             bank_idx,
  output logic [ROW_W-1:0] row
);

  generate
    if (MAP == MAP_HIGH_BIT) begin : g_high
      always_comb begin
        bank_idx = addr[AW-1];
        row      = addr[ROW_W-1:0];
      end
    end else begin : g_low
      always_comb begin
        bank_idx = addr[0];
        row      = addr[AW-1:1];
      end
    end
  endgenerate

endmodule

// File: rtl/bm_slice.sv
module bm_slice #(
  parameter int  DEPTH = 16,
  localparam int ROW_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic             din,
  output logic             dout
);

  logic [DEPTH-1:0] cells_q;
  logic [DEPTH-1:0] cells_d;

  always_comb begin
    cells_d = cells_q;
    if (we) cells_d[row] = din;
  end

  always_ff @(posedge clk) begin
    if (we) cells_q <= cells_d;
  end

  assign dout = cells_q[row];

endmodule

// File: rtl/bm_bank.sv
module bm_bank #(
  parameter int  DEPTH = 16,
  parameter int  WIDTH = 3,
  localparam int ROW_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  // One single-bit slice per data bit, sharing row and strobe.
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      bm_slice #(.DEPTH(DEPTH)) u_slice (
        .clk  (clk),
        .we   (we),
        .row  (row),
        .din  (din[gi]),
        .dout (dout[gi])
      );
    end
  endgenerate

endmodule

// File: rtl/two_bank_mem.sv
module two_bank_mem
  import bankmem_pkg::*;
#(
  parameter bank_map_e MAP        = MAP_HIGH_BIT,
  parameter int        WIDTH      = 3,
  parameter int        BANK_DEPTH = 16,
  localparam int       ROW_W      = $clog2(BANK_DEPTH),
  localparam int       AW         = ROW_W + 1,
  localparam int       NBANK      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_en,
  input  logic             sel,
  input  logic             rd_wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Address decomposition.
  logic             bank_idx;
  logic [ROW_W-1:0] row;

  bm_addr_split #(.MAP(MAP), .ROW_W(ROW_W)) u_split (
    .addr     (addr),
    .bank_idx (bank_idx),
    .row      (row)
  );

  // Gated selects: global enable ANDed into each bank.
  logic             access;
  logic             read_go;
  logic [NBANK-1:0] bank_cs;
  logic [NBANK-1:0] bank_we;
  logic [WIDTH-1:0] bank_q [NBANK];

  assign access  = mem_en & sel;
  assign read_go = access & rd_wr_n;

  genvar gb;
  generate
    for (gb = 0; gb < NBANK; gb++) begin : g_bank
      assign bank_cs[gb] = access & (bank_idx == 1'(gb));
      assign bank_we[gb] = bank_cs[gb] & ~rd_wr_n;

      bm_bank #(.DEPTH(BANK_DEPTH), .WIDTH(WIDTH)) u_bank (
        .clk  (clk),
        .we   (bank_we[gb]),
        .row  (row),
        .din  (wdata),
        .dout (bank_q[gb])
      );
    end
  endgenerate

  // Output buffer register.
  logic [WIDTH-1:0] rd_word;
  logic [WIDTH-1:0] rdata_d;
  logic [WIDTH-1:0] rdata_q;

  assign rd_word = bank_q[bank_idx];

  always_comb begin
    rdata_d = rdata_q;
    if (read_go) rdata_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else if (read_go) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // Checks beside the logic they guard.
  a_r4_one_bank_written: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(bank_we));

  a_r5_r6_idle_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_en && sel) |-> (bank_we == '0));

  a_r2_r3_bank_steer: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bank_we[1] |-> ((MAP == MAP_HIGH_BIT) ? addr[AW-1] : addr[0]));

  a_r7_read_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_en && sel && rd_wr_n) |-> (bank_we == '0));

  a_r8_buffer_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_en && sel && rd_wr_n) |=> $stable(rdata));

endmodule

// File: tb/test_two_bank_mem.sv
`timescale 1ns/1ps
module test_two_bank_mem;
  import bankmem_pkg::*;

  logic       clk;
  logic       rst_n;
  logic       mem_en, sel, rd_wr_n;
  logic [4:0] addr;
  logic [2:0] wdata;
  logic [2:0] rdata_hi, rdata_il;

  int unsigned n_vec;
  int unsigned n_bad;

  logic [2:0] model [32];
  logic [2:0] last_rd;

  two_bank_mem #(.MAP(MAP_HIGH_BIT)) i_two_bank_mem (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .sel(sel), .rd_wr_n(rd_wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata_hi)
  );

  two_bank_mem #(.MAP(MAP_LOW_BIT)) i_two_bank_mem_il (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .sel(sel), .rd_wr_n(rd_wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata_il)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [2:0] exp);
    n_vec++;
    if (rdata_hi !== exp) begin
      n_bad++;
      $display("FAIL %s high-bit map: rdata=%0d expected=%0d", req, rdata_hi, exp);
    end
    n_vec++;
    if (rdata_il !== exp) begin
      n_bad++;
      $display("FAIL %s interleaved map: rdata=%0d expected=%0d", req, rdata_il, exp);
    end
  endtask

  // One cycle: drive at the falling edge, let the rising edge act,
  // update the bench model, compare at the next falling edge.
  task automatic step(input string req, input logic e, input logic s,
                      input logic rw, input logic [4:0] a, input logic [2:0] d);
    mem_en = e; sel = s; rd_wr_n = rw; addr = a; wdata = d;
    @(posedge clk);
    if (e && s && !rw) model[a] = d;
    if (e && s && rw)  last_rd  = model[a];
    @(negedge clk);
    chk(req, last_rd);
  endtask

  function automatic logic [2:0] pat_a(input int a);
    return 3'((a * 5 + 3) % 8);
  endfunction

  function automatic logic [2:0] pat_b(input int a);
    return 3'((a * 3 + 6) % 8);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    n_vec = 0; n_bad = 0; last_rd = 3'd0;
    mem_en = 1'b0; sel = 1'b0; rd_wr_n = 1'b1; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 during reset", 3'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 after release", 3'd0);

    // R1 R2 R3: fill every word, then read every word back.
    for (int a = 0; a < 32; a++) step("R1 fill", 1, 1, 0, 5'(a), pat_a(a));
    chk("R9 no read yet", 3'd0);
    for (int a = 0; a < 32; a++) step("R1 R2 R3 readback", 1, 1, 1, 5'(a), 3'd0);

    // R4: rewrite even words only; odd words must survive.
    for (int a = 0; a < 32; a += 2) step("R4 partial write", 1, 1, 0, 5'(a), pat_b(a));
    for (int a = 31; a >= 0; a--) step("R4 neighbours kept", 1, 1, 1, 5'(a), 3'd0);

    // R6: select low, both directions; nothing changes, buffer holds.
    for (int a = 0; a < 32; a++) step("R6 R8 deselected write", 1, 0, 0, 5'(a), ~model[a]);
    for (int a = 0; a < 32; a++) step("R6 R8 deselected read", 1, 0, 1, 5'(a), 3'd0);

    // R5: global enable low with select high.
    for (int a = 0; a < 32; a++) step("R5 disabled write", 0, 1, 0, 5'(a), ~model[a]);
    for (int a = 0; a < 32; a++) step("R5 disabled read", 0, 1, 1, 5'(31 - a), 3'd0);
    for (int a = 0; a < 32; a++) step("R5 R6 contents kept", 1, 1, 1, 5'(a), 3'd0);

    // R7: back-to-back reads of alternating banks, read right after write.
    for (int a = 0; a < 16; a++) begin
      step("R7 alternate lo", 1, 1, 1, 5'(a), 3'd0);
      step("R7 alternate hi", 1, 1, 1, 5'(31 - a), 3'd0);
    end
    for (int a = 0; a < 32; a++) begin
      step("R4 R8 write holds buffer", 1, 1, 0, 5'(a), 3'(a));
      step("R7 read after write", 1, 1, 1, 5'(a), 3'd0);
      step("R8 idle hold", 1, 0, 1, 5'(a ^ 1), 3'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule